// File: doc/BRIEF.md
# Register Specifier Redirection Table

This block sits in front of a small processor's architected register file and decides, for every register access, whether the access goes to the architected file or to one of several custom register structures such as queues, stacks or circular buffers. It holds one entry for each of the sixteen architected register specifiers. Each entry records whether the specifier is redirected, which structure it points to, and the setup value the structure was given when the mapping was made.

Decode-stage reads and writeback-stage writes are looked up against the table. For each one, the block reports whether the specifier is redirected and routes the data accordingly. A single map-toggle command, issued from decode, flips the entry for its specifier. If the entry is empty, the command fills it and sends the chosen structure a configure pulse carrying the setup value. If the entry is already in use, the command clears it and sends the structure that was mapped a release pulse.

Top module: `regmap_redirect`

## Requirements
- R1: While reset is held and after it is released, every entry is empty. Every read returns the architected data with `rd_hit` low, and every write goes to the architected file.
- R2: A read of an empty specifier gives `rd_hit`=0, `rd_sid`=0 and `rd_setup`=0, and `rd_data` equals that port's `arch_rd_data` slice.
- R3: Writeback to an empty specifier raises `arch_we`, with `arch_waddr` equal to the specifier and `cust_we` low. Writeback to a redirected specifier raises `cust_we`, with `cust_wsid` equal to the stored structure number and `arch_we` low. With `wb_en` low, neither strobe is raised.
- R4: A read of a redirected specifier gives `rd_hit`=1. It also gives the stored structure number on `rd_sid` and the stored setup on `rd_setup`, and `rd_data` equals that port's `cust_rd_data` slice.
- R5: A toggle command for an empty specifier fills the entry with `cmd_sid` and `cmd_setup`. In the same cycle it raises `cfg_pulse` for that cycle only, with `cfg_sid`=`cmd_sid` and `cfg_setup`=`cmd_setup`, and `rel_pulse` stays low.
- R6: A toggle command for a redirected specifier clears the entry. In the same cycle it raises `rel_pulse` for one cycle, with `rel_sid` equal to the stored structure number (not `cmd_sid`), and `cfg_pulse` stays low.
- R7: A toggle command changes the table from the following cycle on. Reads and writebacks in the same cycle as the command see the old entry. Without a command, the table does not change.
- R8: A toggle command changes only the entry of its own specifier. This holds for specifiers 0 and 15 as well.
- R9: Each read port looks up its own specifier independently, so one port can hit while the other misses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Map-toggle command present in decode |
| cmd_spec | input | 4 | Specifier the command targets |
| cmd_setup | input | 4 | Setup value for a new mapping |
| cmd_sid | input | 3 | Structure number for a new mapping |
| rd_spec | input | NRD*4 | Read specifiers, port p in bits [p*4 +: 4] |
| arch_rd_data | input | NRD*32 | Data from the architected file, per port |
| cust_rd_data | input | NRD*32 | Data from the custom structures, per port |
| rd_hit | output | NRD | Read specifier is redirected, per port |
| rd_sid | output | NRD*3 | Target structure per port (0 when not redirected) |
| rd_setup | output | NRD*4 | Stored setup per port (0 when not redirected) |
| rd_data | output | NRD*32 | Routed read data per port |
| wb_en | input | 1 | Writeback request |
| wb_spec | input | 4 | Writeback specifier |
| wb_data | input | 32 | Writeback data |
| arch_we | output | 1 | Write strobe to the architected file |
| arch_waddr | output | 4 | Architected write address |
| arch_wdata | output | 32 | Architected write data |
| cust_we | output | 1 | Write strobe to the custom structures |
| cust_wsid | output | 3 | Structure number for the custom write |
| cust_wdata | output | 32 | Custom write data |
| cfg_pulse | output | 1 | One-cycle configure pulse for a new mapping |
| cfg_sid | output | 3 | Structure being configured |
| cfg_setup | output | 4 | Setup value sent with the configure pulse |
| rel_pulse | output | 1 | One-cycle release pulse for a removed mapping |
| rel_sid | output | 3 | Structure being released |

## Verification
A toggle command and an access to the same specifier can arrive in the same cycle, because decode issues the command while decode reads and writebacks from older instructions continue. The bench provokes this by issuing a map command and, in that same cycle, a read and a writeback of the target specifier. It checks that both still route to the architected file while the configure pulse is raised, and that the next cycle routes both to the new structure. It then does the same with an unmap command, where the same-cycle access must still hit the structure being released.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  parameter int SPEC_W   = 4;
  parameter int NSPEC    = 1 << SPEC_W;
  parameter int STRUCT_W = 3;
  parameter int SETUP_W  = 4;

  typedef struct packed {
    logic                vld;
    logic [STRUCT_W-1:0] sid;
    logic [SETUP_W-1:0]  setup;
  } map_ent_t;

  // Toggle rule: an empty entry is filled, a filled entry is cleared.
  function automatic map_ent_t toggle_ent(input map_ent_t cur,
                                          input logic [STRUCT_W-1:0] sid,
                                          input logic [SETUP_W-1:0] setup);
    map_ent_t n;
    if (cur.vld) n = '0;
    else begin
      n.vld   = 1'b1;
      n.sid   = sid;
      n.setup = setup;
    end
    return n;
  endfunction

  // Select routed data by hit.
  function automatic logic [63:0] route_sel(input logic hit,
                                            input logic [63:0] arch_v,
                                            input logic [63:0] cust_v);
    return hit ? cust_v : arch_v;
  endfunction
endpackage

// File: rtl/regmap_table.sv
module regmap_table
  import regmap_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [SPEC_W-1:0]           cmd_spec,
  input  logic [STRUCT_W-1:0]         cmd_sid,
  input  logic [SETUP_W-1:0]          cmd_setup,
  output map_ent_t [NSPEC-1:0]        tbl,
  output logic                        cfg_pulse,
  output logic [STRUCT_W-1:0]         cfg_sid,
  output logic [SETUP_W-1:0]          cfg_setup,
  output logic                        rel_pulse,
  output logic [STRUCT_W-1:0]         rel_sid
);
  map_ent_t [NSPEC-1:0] tbl_q;
  map_ent_t             cur;
  map_ent_t             nxt;

  always_comb begin
    cur = tbl_q[cmd_spec];
    nxt = toggle_ent(cur, cmd_sid, cmd_setup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else if (cmd_valid) tbl_q[cmd_spec] <= nxt;
  end

  assign tbl       = tbl_q;
  assign cfg_pulse = cmd_valid & ~cur.vld;
  assign cfg_sid   = cmd_sid;
  assign cfg_setup = cmd_setup;
  assign rel_pulse = cmd_valid & cur.vld;
  assign rel_sid   = cur.sid;
endmodule

// File: rtl/regmap_rd_port.sv
module regmap_rd_port
  import regmap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  map_ent_t [NSPEC-1:0] tbl,
  input  logic [SPEC_W-1:0]    spec,
  input  logic [DATA_W-1:0]    arch_data,
  input  logic [DATA_W-1:0]    cust_data,
  output logic                 hit,
  output logic [STRUCT_W-1:0]  sid,
  output logic [SETUP_W-1:0]   setup,
  output logic [DATA_W-1:0]    data
);
  map_ent_t    ent;
  logic [63:0] sel;

  always_comb begin
    ent   = tbl[spec];
    hit   = ent.vld;
    sid   = ent.vld ? ent.sid   : '0;
    setup = ent.vld ? ent.setup : '0;
    sel   = route_sel(ent.vld, 64'(arch_data), 64'(cust_data));
    data  = sel[DATA_W-1:0];
  end
endmodule

// File: rtl/regmap_wr_route.sv
module regmap_wr_route
  import regmap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  map_ent_t [NSPEC-1:0] tbl,
  input  logic                 wb_en,
  input  logic [SPEC_W-1:0]    wb_spec,
  input  logic [DATA_W-1:0]    wb_data,
  output logic                 arch_we,
  output logic [SPEC_W-1:0]    arch_waddr,
  output logic [DATA_W-1:0]    arch_wdata,
  output logic                 cust_we,
  output logic [STRUCT_W-1:0]  cust_wsid,
  output logic [DATA_W-1:0]    cust_wdata
);
  map_ent_t ent;

  always_comb begin
    ent        = tbl[wb_spec];
    arch_we    = wb_en & ~ent.vld;
    cust_we    = wb_en & ent.vld;
    arch_waddr = wb_spec;
    cust_wsid  = ent.vld ? ent.sid : '0;
    arch_wdata = wb_data;
    cust_wdata = wb_data;
  end
endmodule

// File: rtl/regmap_redirect.sv
module regmap_redirect
  import regmap_pkg::*;
#(
  parameter int NRD    = 2,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [SPEC_W-1:0]          cmd_spec,
  input  logic [SETUP_W-1:0]         cmd_setup,
  input  logic [STRUCT_W-1:0]        cmd_sid,
  input  logic [NRD*SPEC_W-1:0]      rd_spec,
  input  logic [NRD*DATA_W-1:0]      arch_rd_data,
  input  logic [NRD*DATA_W-1:0]      cust_rd_data,
  output logic [NRD-1:0]             rd_hit,
  output logic [NRD*STRUCT_W-1:0]    rd_sid,
  output logic [NRD*SETUP_W-1:0]     rd_setup,
  output logic [NRD*DATA_W-1:0]      rd_data,
  input  logic                       wb_en,
  input  logic [SPEC_W-1:0]          wb_spec,
  input  logic [DATA_W-1:0]          wb_data,
  output logic                       arch_we,
  output logic [SPEC_W-1:0]          arch_waddr,
  output logic [DATA_W-1:0]          arch_wdata,
  output logic                       cust_we,
  output logic [STRUCT_W-1:0]        cust_wsid,
  output logic [DATA_W-1:0]          cust_wdata,
  output logic                       cfg_pulse,
  output logic [STRUCT_W-1:0]        cfg_sid,
  output logic [SETUP_W-1:0]         cfg_setup,
  output logic                       rel_pulse,
  output logic [STRUCT_W-1:0]        rel_sid
);
  map_ent_t [NSPEC-1:0] tbl;
  logic     [NSPEC-1:0] map_valid;  // brought out for the checker

  regmap_table u_tbl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_spec(cmd_spec),
    .cmd_sid(cmd_sid), .cmd_setup(cmd_setup), .tbl(tbl),
    .cfg_pulse(cfg_pulse), .cfg_sid(cfg_sid), .cfg_setup(cfg_setup),
    .rel_pulse(rel_pulse), .rel_sid(rel_sid)
  );

  for (genvar s = 0; s < NSPEC; s++) begin : g_vld
    assign map_valid[s] = tbl[s].vld;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    regmap_rd_port #(.DATA_W(DATA_W)) u_rd (
      .tbl(tbl),
      .spec(rd_spec[p*SPEC_W +: SPEC_W]),
      .arch_data(arch_rd_data[p*DATA_W +: DATA_W]),
      .cust_data(cust_rd_data[p*DATA_W +: DATA_W]),
      .hit(rd_hit[p]),
      .sid(rd_sid[p*STRUCT_W +: STRUCT_W]),
      .setup(rd_setup[p*SETUP_W +: SETUP_W]),
      .data(rd_data[p*DATA_W +: DATA_W])
    );
  end

  regmap_wr_route #(.DATA_W(DATA_W)) u_wr (
    .tbl(tbl), .wb_en(wb_en), .wb_spec(wb_spec), .wb_data(wb_data),
    .arch_we(arch_we), .arch_waddr(arch_waddr), .arch_wdata(arch_wdata),
    .cust_we(cust_we), .cust_wsid(cust_wsid), .cust_wdata(cust_wdata)
  );
endmodule

// File: rtl/regmap_chk.sv
module regmap_chk
  import regmap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [SPEC_W-1:0] cmd_spec,
  input logic [NSPEC-1:0]  map_valid,
  input logic              cfg_pulse,
  input logic              rel_pulse,
  input logic              wb_en,
  input logic              arch_we,
  input logic              cust_we
);
  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> map_valid == '0); // R1
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(arch_we && cust_we)); // R3
  AST_CUST_NEEDS_WB: assert property (@(posedge clk) disable iff (!rst_n) cust_we |-> wb_en); // R3
  AST_CFG_FILLS: assert property (@(posedge clk) disable iff (!rst_n) cfg_pulse |=> map_valid[$past(cmd_spec)]); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_pulse && rel_pulse)); // R5
  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rel_pulse |=> !map_valid[$past(cmd_spec)]); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> $stable(map_valid)); // R7
  AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $countones(map_valid ^ $past(map_valid)) <= 1); // R8
endmodule

bind regmap_redirect regmap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_spec(cmd_spec),
  .map_valid(map_valid), .cfg_pulse(cfg_pulse), .rel_pulse(rel_pulse),
  .wb_en(wb_en), .arch_we(arch_we), .cust_we(cust_we)
);

// File: tb/sim_regmap_redirect.sv
`timescale 1ns/1ps
module sim_regmap_redirect;
  localparam int NRD = 2;
  localparam int DW  = 32;
  localparam logic [31:0] A0 = 32'hA0A0_0000, A1 = 32'hA1A1_0001;
  localparam logic [31:0] C0 = 32'hC0C0_0000, C1 = 32'hC1C1_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_spec = '0, cmd_setup = '0;
  logic [2:0] cmd_sid = '0;
  logic [NRD*4-1:0] rd_spec = '0;
  logic [NRD*DW-1:0] arch_rd_data, cust_rd_data;
  logic [NRD-1:0] rd_hit;
  logic [NRD*3-1:0] rd_sid;
  logic [NRD*4-1:0] rd_setup;
  logic [NRD*DW-1:0] rd_data;
  logic wb_en = 1'b0;
  logic [3:0] wb_spec = '0;
  logic [DW-1:0] wb_data = 32'h1234_5678;
  logic arch_we, cust_we, cfg_pulse, rel_pulse;
  logic [3:0] arch_waddr, cfg_setup;
  logic [DW-1:0] arch_wdata, cust_wdata;
  logic [2:0] cust_wsid, cfg_sid, rel_sid;

  int n_chk = 0, n_fail = 0, cyc = 0;

  assign arch_rd_data = {A1, A0};
  assign cust_rd_data = {C1, C0};

  always #4 clk = ~clk;

  regmap_redirect #(.NRD(NRD), .DATA_W(DW)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cmd_valid = 1'b0; wb_en = 1'b0;
  endtask

  task automatic rd_expect(input int p, input string req, input logic hit,
                           input logic [2:0] sid, input logic [3:0] setup);
    chk({req, " hit"}, rd_hit[p], hit);
    chk({req, " sid"}, rd_sid[p*3 +: 3], hit ? sid : 3'd0);
    chk({req, " setup"}, rd_setup[p*4 +: 4], hit ? setup : 4'd0);
    chk({req, " data"}, rd_data[p*DW +: DW], hit ? (p == 0 ? C0 : C1) : (p == 0 ? A0 : A1));
  endtask

  task automatic t_reset();
    rd_spec = {4'd9, 4'd3}; wb_en = 1'b1; wb_spec = 4'd9;
    #2;
    rd_expect(0, "R1 in reset", 1'b0, 0, 0);
    chk("R1 in reset wb", {arch_we, cust_we}, 2'b10);
    @(negedge clk); rst_n = 1'b1; step();
    rd_expect(1, "R1 after reset", 1'b0, 0, 0);
    chk("R1 after reset wb", {arch_we, cust_we}, 2'b10);
    idle();
  endtask

  task automatic t_unmapped();
    rd_spec = {4'd15, 4'd3}; wb_en = 1'b1; wb_spec = 4'd5; #2;
    rd_expect(0, "R2 port0", 1'b0, 0, 0);
    rd_expect(1, "R2 port1", 1'b0, 0, 0);
    chk("R3 unmapped arch_we", {arch_we, cust_we}, 2'b10);
    chk("R3 unmapped waddr", arch_waddr, 4'd5);
    chk("R3 unmapped wdata", arch_wdata, 32'h1234_5678);
    wb_en = 1'b0; #1;
    chk("R3 no wb strobes", {arch_we, cust_we}, 2'b00);
    step();
  endtask

  task automatic t_map_same_cycle();
    cmd_valid = 1'b1; cmd_spec = 4'd6; cmd_sid = 3'd2; cmd_setup = 4'd9;
    rd_spec = {4'd7, 4'd6}; wb_en = 1'b1; wb_spec = 4'd6; #2;
    chk("R5 cfg pulse", {cfg_pulse, rel_pulse}, 2'b10);
    chk("R5 cfg sid", cfg_sid, 3'd2);
    chk("R5 cfg setup", cfg_setup, 4'd9);
    rd_expect(0, "R7 same-cycle read old", 1'b0, 0, 0);
    chk("R7 same-cycle wb old", {arch_we, cust_we}, 2'b10);
    step(); cmd_valid = 1'b0; #2;
    chk("R5 pulse one cycle", {cfg_pulse, rel_pulse}, 2'b00);
    rd_expect(0, "R4 mapped read", 1'b1, 3'd2, 4'd9);
    rd_expect(1, "R9 other port miss", 1'b0, 0, 0);
    chk("R3 mapped wb strobes", {arch_we, cust_we}, 2'b01);
    chk("R3 mapped wb sid", cust_wsid, 3'd2);
    chk("R3 mapped wb data", cust_wdata, 32'h1234_5678);
    wb_spec = 4'd7; #1;
    chk("R8 neighbour wb arch", {arch_we, cust_we}, 2'b10);
    step(); idle(); #2;
    rd_expect(0, "R7 no cmd stable", 1'b1, 3'd2, 4'd9);
    step();
  endtask

  task automatic t_unmap();
    cmd_valid = 1'b1; cmd_spec = 4'd6; cmd_sid = 3'd5; cmd_setup = 4'd1;
    rd_spec = {4'd6, 4'd6}; wb_en = 1'b1; wb_spec = 4'd6; #2;
    chk("R6 rel pulse", {cfg_pulse, rel_pulse}, 2'b01);
    chk("R6 rel sid stored", rel_sid, 3'd2);
    rd_expect(1, "R7 same-cycle unmap read old", 1'b1, 3'd2, 4'd9);
    chk("R7 same-cycle unmap wb old", {arch_we, cust_we}, 2'b01);
    step(); cmd_valid = 1'b0; #2;
    chk("R6 pulse one cycle", {cfg_pulse, rel_pulse}, 2'b00);
    rd_expect(0, "R6 cleared read", 1'b0, 0, 0);
    chk("R6 cleared wb", {arch_we, cust_we}, 2'b10);
    step(); idle();
  endtask

  task automatic t_edges();
    cmd_valid = 1'b1; cmd_spec = 4'd0; cmd_sid = 3'd7; cmd_setup = 4'd15; step();
    cmd_spec = 4'd15; cmd_sid = 3'd1; cmd_setup = 4'd4; step();
    cmd_spec = 4'd6; cmd_sid = 3'd4; cmd_setup = 4'd3; step();
    cmd_valid = 1'b0;
    rd_spec = {4'd15, 4'd0}; #2;
    rd_expect(0, "R8 spec0", 1'b1, 3'd7, 4'd15);
    rd_expect(1, "R8 spec15", 1'b1, 3'd1, 4'd4);
    rd_spec = {4'd1, 4'd6}; #1;
    rd_expect(0, "R5 remap new sid", 1'b1, 3'd4, 4'd3);
    rd_expect(1, "R8 spec1 untouched", 1'b0, 0, 0);
    cmd_valid = 1'b1; cmd_spec = 4'd0; step(); cmd_valid = 1'b0;
    rd_spec = {4'd15, 4'd0}; #2;
    rd_expect(0, "R8 spec0 removed", 1'b0, 0, 0);
    rd_expect(1, "R8 spec15 kept", 1'b1, 3'd1, 4'd4);
    step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_unmapped();
        t_map_same_cycle();
        t_unmap();
        t_edges();
      end
      begin
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule